// File: doc/BRIEF.md
# 8b/10b Encoding Serializer

This block is the transmit half of a simple serial link. A byte on the parallel input is taken into a holding register on a rising clock edge while the capture enable is high. On the next edge the held byte is turned into a 10-bit 8b/10b data code group, and the running disparity is updated. The encoder works as a 5b/6b stage followed by a 3b/4b stage. The code group is kept in an encoded-word register. A shifter then sends it out one bit per clock, least significant bit first, while the shift enable is high.

Capture, encoding and shifting each advance through their own register stage. A producer can therefore present a byte once every ten shift cycles and keep the line busy without gaps. If no fresh byte has arrived by the end of a word, the shifter sends the last code group again. Control characters and comma insertion are not supported. Only data characters are encoded.

The shifter is a three-state machine. The transitions are as follows:
- SH_EMPTY: no code group has been loaded since reset. The output is held low. It moves to SH_SEND on the first edge where an encoded word is valid, and loads that word on the same edge.
- SH_SEND: the machine is shifting. It stays in SH_SEND while the shift enable is high, and moves to SH_HOLD on an edge where the shift enable is low.
- SH_HOLD: the shift position is frozen. It returns to SH_SEND on an edge where the shift enable is high, and consumes the shown bit on that same edge.

Top module: `serenc_top`

## Requirements
- R1: `byte_in` is taken into the holding register only on a rising edge where `data_en` is 1. Values presented while `data_en` is 0 never reach the line.
- R2: Each captured byte HGFEDCBA (bit 7 = H) is encoded once, on the edge after capture, into the 8b/10b data code group abcdei fghj.
  - EDCBA selects the 6-bit sub-block and HGF selects the 4-bit sub-block.
  - An unbalanced sub-block, or one of the two balanced ones that have alternate forms (EDCBA = 7, HGF = 3), is sent complemented when the running disparity is positive.
  - HGF = 7 uses the alternate form 0111/1000 when the disparity is negative and EDCBA is 17, 18 or 20, or when the disparity is positive and EDCBA is 11, 13 or 14.
  - Every code group carries 4, 5 or 6 ones.
- R3: The running disparity starts negative after reset. It toggles after each sub-block whose ones count is not half its width.
- R4: Bits leave least significant first: a, b, c, d, e, i, f, g, h, j.
- R5: `ser_out` is 0 in every cycle where `ser_en` is 0. A shift position is consumed only on an edge where `ser_en` is 1. A word interrupted by a low `ser_en` resumes at the bit where it stopped.
- R6: After the tenth bit is consumed, the shifter reloads from the encoded-word register. If no new byte has been encoded, the same code group is sent again.
- R7: Latency from an empty shifter is fixed. For a byte captured at edge N, bit a is on `ser_out` during the cycle after edge N+2, provided `ser_en` is 1.
- R8: An encoded-word update on the same edge as a reload is not seen by that reload. The older group is sent, and the new group follows at the next word boundary.
- R9: Reset is synchronous and active high. `ser_out` is 0 while `rst` is 1. Reset clears the held byte, the encoded word and the disparity, so `ser_out` stays 0 until a new byte is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| data_en | input | 1 | Capture enable for the parallel byte |
| byte_in | input | 8 | Parallel data byte, bit 7 = H, bit 0 = A |
| ser_en | input | 1 | Shift enable for the serial output |
| ser_out | output | 1 | Serial line, code-group bit a first |

## Verification
Two events can fall on the same edge: the encoded-word register taking a new code group, and the shifter reloading at the end of a word. The bench causes this by capturing a second byte exactly one cycle before the first word finishes, so the new group is written on the reload edge itself. The result is judged on the serial stream. It must show the first group twice and then the second group. The second group must be encoded against the disparity left by the first group, which proves it was encoded only once. A full sweep of all 256 bytes back to back also checks every group against an arithmetic model of the code tables and the running disparity.

// File: rtl/serenc_pkg.sv
package serenc_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned LO_W   = 5;
    localparam int unsigned HI_W   = DATA_W - LO_W;
    localparam int unsigned SUB6_W = LO_W + 1;
    localparam int unsigned SUB4_W = HI_W + 1;
    localparam int unsigned CODE_W = SUB6_W + SUB4_W;
    localparam int unsigned CNT_W  = $clog2(CODE_W);

    typedef enum logic [1:0] {
        SH_EMPTY = 2'd0,
        SH_SEND  = 2'd1,
        SH_HOLD  = 2'd2
    } shift_state_e;
endpackage

// File: rtl/serenc_sub6.sv
module serenc_sub6
    import serenc_pkg::*;
(
    input  logic [LO_W-1:0]   lo_bits,
    input  logic              rd_in,
    output logic [SUB6_W-1:0] code6,
    output logic              rd_out
);
    logic [SUB6_W-1:0] base;
    logic              unbal;
    logic              swap;

    always_comb begin
        unique case (lo_bits)
            5'd0:  base = 6'b100111;
            5'd1:  base = 6'b011101;
            5'd2:  base = 6'b101101;
            5'd3:  base = 6'b110001;
            5'd4:  base = 6'b110101;
            5'd5:  base = 6'b101001;
            5'd6:  base = 6'b011001;
            5'd7:  base = 6'b111000;
            5'd8:  base = 6'b111001;
            5'd9:  base = 6'b100101;
            5'd10: base = 6'b010101;
            5'd11: base = 6'b110100;
            5'd12: base = 6'b001101;
            5'd13: base = 6'b101100;
            5'd14: base = 6'b011100;
            5'd15: base = 6'b010111;
            5'd16: base = 6'b011011;
            5'd17: base = 6'b100011;
            5'd18: base = 6'b010011;
            5'd19: base = 6'b110010;
            5'd20: base = 6'b001011;
            5'd21: base = 6'b101010;
            5'd22: base = 6'b011010;
            5'd23: base = 6'b111010;
            5'd24: base = 6'b110011;
            5'd25: base = 6'b100110;
            5'd26: base = 6'b010110;
            5'd27: base = 6'b110110;
            5'd28: base = 6'b001110;
            5'd29: base = 6'b101110;
            5'd30: base = 6'b011110;
            default: base = 6'b101011;
        endcase
    end

    // base is the negative-disparity form (a is the MSB)
    assign unbal  = ($countones(base) != 3);
    assign swap   = rd_in && (unbal || (lo_bits == 5'd7));
    assign code6  = swap ? ~base : base;
    assign rd_out = rd_in ^ unbal;

    always_comb begin
        assert_sub6_weight_R2: assert ($countones(code6) >= 2 && $countones(code6) <= 4);
    end
endmodule

// File: rtl/serenc_sub4.sv
module serenc_sub4
    import serenc_pkg::*;
(
    input  logic [HI_W-1:0]   hi_bits,
    input  logic [LO_W-1:0]   lo_bits,
    input  logic              rd_in,
    output logic [SUB4_W-1:0] code4,
    output logic              rd_out
);
    logic [SUB4_W-1:0] base;
    logic              alt7;
    logic              unbal;
    logic              swap;

    assign alt7 = (!rd_in && (lo_bits == 5'd17 || lo_bits == 5'd18 || lo_bits == 5'd20)) ||
                  ( rd_in && (lo_bits == 5'd11 || lo_bits == 5'd13 || lo_bits == 5'd14));

    always_comb begin
        unique case (hi_bits)
            3'd0:    base = 4'b1011;
            3'd1:    base = 4'b1001;
            3'd2:    base = 4'b0101;
            3'd3:    base = 4'b1100;
            3'd4:    base = 4'b1101;
            3'd5:    base = 4'b1010;
            3'd6:    base = 4'b0110;
            default: base = alt7 ? 4'b0111 : 4'b1110;
        endcase
    end

    assign unbal  = ($countones(base) != 2);
    assign swap   = rd_in && (unbal || (hi_bits == 3'd3));
    assign code4  = swap ? ~base : base;
    assign rd_out = rd_in ^ unbal;

    always_comb begin
        assert_sub4_weight_R2: assert ($countones(code4) >= 1 && $countones(code4) <= 3);
    end
endmodule

// File: rtl/serenc_shift.sv
module serenc_shift
    import serenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              word_vld,
    input  logic [CODE_W-1:0] word,
    output logic              ser_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

    shift_state_e      state, nxt;
    logic [CODE_W-1:0] sh_q;
    logic [CNT_W-1:0]  pos_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SH_EMPTY;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SH_EMPTY: nxt = word_vld ? SH_SEND : SH_EMPTY;
            SH_SEND:  nxt = ser_en   ? SH_SEND : SH_HOLD;
            SH_HOLD:  nxt = ser_en   ? SH_SEND : SH_HOLD;
            default:  nxt = SH_EMPTY;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            pos_q <= '0;
        end else begin
            unique case (state)
                SH_EMPTY: begin
                    if (word_vld) begin
                        sh_q  <= word;
                        pos_q <= '0;
                    end
                end
                SH_SEND, SH_HOLD: begin
                    if (ser_en) begin
                        if (pos_q == LAST) begin
                            sh_q  <= word;
                            pos_q <= '0;
                        end else begin
                            sh_q  <= sh_q >> 1;
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ser_out = 1'b0;
        if (!rst && ser_en && state != SH_EMPTY) ser_out = sh_q[0];
    end

    always_comb begin
        assert_pos_bound_R6: assert (rst || pos_q <= LAST);
    end

    assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (state != SH_EMPTY && !ser_en) |=> ($stable(sh_q) && $stable(pos_q)));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (state != SH_EMPTY && ser_en && pos_q == LAST) |=> (pos_q == '0 && sh_q == $past(word)));

    assert_first_load_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SH_EMPTY && word_vld) |=> (state == SH_SEND && pos_q == '0));
endmodule

// File: rtl/serenc_top.sv
module serenc_top
    import serenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_en,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ser_en,
    output logic              ser_out
);
    logic [DATA_W-1:0] hold_q;
    logic              hold_new;
    logic [CODE_W-1:0] enc_q;
    logic              enc_vld;
    logic              rd_q;

    logic [SUB6_W-1:0] c6;
    logic [SUB4_W-1:0] c4;
    logic              rd_mid, rd_end;
    logic [CODE_W-1:0] grp;
    logic [CODE_W-1:0] enc_next;

    // capture stage
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_new <= 1'b0;
        end else begin
            if (data_en) hold_q <= byte_in;
            hold_new <= data_en;
        end
    end

    serenc_sub6 u_sub6 (
        .lo_bits (hold_q[LO_W-1:0]),
        .rd_in   (rd_q),
        .code6   (c6),
        .rd_out  (rd_mid)
    );

    serenc_sub4 u_sub4 (
        .hi_bits (hold_q[DATA_W-1:LO_W]),
        .lo_bits (hold_q[LO_W-1:0]),
        .rd_in   (rd_mid),
        .code4   (c4),
        .rd_out  (rd_end)
    );

    // group is abcdei fghj with a at the MSB; the stored word puts a at bit 0
    assign grp = {c6, c4};
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_order
        assign enc_next[gi] = grp[CODE_W-1-gi];
    end

    // encode stage
    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q   <= '0;
            enc_vld <= 1'b0;
            rd_q    <= 1'b0;
        end else if (hold_new) begin
            enc_q   <= enc_next;
            enc_vld <= 1'b1;
            rd_q    <= rd_end;
        end
    end

    serenc_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_en   (ser_en),
        .word_vld (enc_vld),
        .word     (enc_q),
        .ser_out  (ser_out)
    );

    assert_group_weight_R2: assert property (@(posedge clk) disable iff (rst)
        enc_vld |-> ($countones(enc_q) >= 4 && $countones(enc_q) <= 6));

    assert_rd_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (enc_vld && $countones(enc_q) != 5) |-> (rd_q == ($countones(enc_q) == 6)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!enc_vld && !hold_new && !rd_q));
endmodule

// File: tb/tb_serenc_top.sv
module tb_serenc_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_en = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       ser_en = 1'b0;
    logic       ser_out;

    int   errors = 0;
    int   checks = 0;
    logic smp;
    logic m_rd;
    logic [9:0] exp_w [0:255];

    always #2.5 clk = ~clk;

    serenc_top dut (
        .clk     (clk),
        .rst     (rst),
        .data_en (data_en),
        .byte_in (byte_in),
        .ser_en  (ser_en),
        .ser_out (ser_out)
    );

    function automatic logic [5:0] t6(input logic [4:0] x);
        case (x)
            5'd0: return 6'b100111;  5'd1: return 6'b011101;
            5'd2: return 6'b101101;  5'd3: return 6'b110001;
            5'd4: return 6'b110101;  5'd5: return 6'b101001;
            5'd6: return 6'b011001;  5'd7: return 6'b111000;
            5'd8: return 6'b111001;  5'd9: return 6'b100101;
            5'd10: return 6'b010101; 5'd11: return 6'b110100;
            5'd12: return 6'b001101; 5'd13: return 6'b101100;
            5'd14: return 6'b011100; 5'd15: return 6'b010111;
            5'd16: return 6'b011011; 5'd17: return 6'b100011;
            5'd18: return 6'b010011; 5'd19: return 6'b110010;
            5'd20: return 6'b001011; 5'd21: return 6'b101010;
            5'd22: return 6'b011010; 5'd23: return 6'b111010;
            5'd24: return 6'b110011; 5'd25: return 6'b100110;
            5'd26: return 6'b010110; 5'd27: return 6'b110110;
            5'd28: return 6'b001110; 5'd29: return 6'b101110;
            5'd30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    // reference model: encodes with m_rd and advances it (R2, R3)
    task automatic model(input logic [7:0] b, output logic [9:0] w);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] s4;
        logic [9:0] g;
        bit         alt;
        x  = b[4:0];
        y  = b[7:5];
        s6 = t6(x);
        if (m_rd && ($countones(s6) != 3 || x == 5'd7)) s6 = ~s6;
        if ($countones(s6) != 3) m_rd = ~m_rd;
        alt = m_rd ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                   : (x == 5'd17 || x == 5'd18 || x == 5'd20);
        case (y)
            3'd0: s4 = 4'b1011;
            3'd1: s4 = 4'b1001;
            3'd2: s4 = 4'b0101;
            3'd3: s4 = 4'b1100;
            3'd4: s4 = 4'b1101;
            3'd5: s4 = 4'b1010;
            3'd6: s4 = 4'b0110;
            default: s4 = alt ? 4'b0111 : 4'b1110;
        endcase
        if (m_rd && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
        if ($countones(s4) != 2) m_rd = ~m_rd;
        g = {s6, s4};
        for (int i = 0; i < 10; i++) w[i] = g[9-i];
    endtask

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one cycle: drive, sample mid-cycle, cross the next rising edge
    task automatic step(input logic de, input logic [7:0] d, input logic se);
        data_en = de;
        byte_in = d;
        ser_en  = se;
        @(negedge clk);
        smp = ser_out;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h5A, 1'b1);
            chk("R9 output low in reset", {9'd0, smp}, 10'd0);
        end
        rst  = 1'b0;
        m_rd = 1'b0;
    endtask

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog R6: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] got_prev;
        logic [9:0] got_cur;
        logic [9:0] wa, wb;
        logic [9:0] seq [0:32];
        logic [9:0] got;

        @(posedge clk);
        #1;
        do_reset();

        // Sweep of all bytes, one per word, shifting continuously (R1 R2 R3 R4 R6 R7)
        got_prev = '0;
        got_cur  = '0;
        for (int n = 0; n <= 256; n++) begin
            if (n < 256) model(8'(n), exp_w[n]);
            for (int s = 0; s < 10; s++) begin
                if (s == 0 && n < 256) step(1'b1, 8'(n), 1'b1);
                else                   step(1'b0, ~8'(n), 1'b1);
                if (s <= 2) begin
                    if (n == 0) chk("R7 empty shifter low", {9'd0, smp}, 10'd0);
                    else got_prev[s+7] = smp;
                    if (s == 2 && n > 0) chk($sformatf("R2 R4 byte %0d", n-1), got_prev, exp_w[n-1]);
                end else begin
                    got_cur[s-3] = smp;
                end
            end
            got_prev = got_cur;
        end
        chk("R6 repeat of last group", {3'd0, got_cur[6:0]}, {3'd0, exp_w[255][6:0]});

        // Freeze and resume inside a word (R5)
        do_reset();
        model(8'hA5, wa);
        step(1'b1, 8'hA5, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        got = '0;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 8'hFF, 1'b1);
            got[i] = smp;
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h3C, 1'b0);
            chk("R5 low while ser_en low", {9'd0, smp}, 10'd0);
        end
        for (int i = 4; i < 10; i++) begin
            step(1'b0, 8'h00, 1'b1);
            got[i] = smp;
        end
        chk("R5 word resumes intact", got, wa);

        // Encode update on the reload edge (R8), alternate 4b form (R2)
        do_reset();
        model(8'h00, wa);
        model(8'hF1, wb);
        for (int t = 0; t <= 32; t++) begin
            if (t == 0)       step(1'b1, 8'h00, 1'b1);
            else if (t == 11) step(1'b1, 8'hF1, 1'b1);
            else              step(1'b0, 8'(t * 37), 1'b1);
            seq[t] = {9'd0, smp};
        end
        for (int w = 0; w < 3; w++) begin
            got = '0;
            for (int i = 0; i < 10; i++) got[i] = seq[3 + 10*w + i][0];
            if (w < 2) chk($sformatf("R8 older group word %0d", w), got, wa);
            else       chk("R8 newer group follows R3", got, wb);
        end

        // Reset mid-word clears everything (R9); data ignored without enable (R1)
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        do_reset();
        for (int i = 0; i < 14; i++) begin
            step(1'b0, 8'(i * 19 + 1), 1'b1);
            chk("R9 R1 nothing sent after reset", {9'd0, smp}, 10'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule